// File: doc/BRIEF.md
# Snooping MESI Line State Controller

This block keeps one cache line coherent across a small group of private caches. In the default build there are six cores. All of them sit on one shared snooping bus, and the same bus reaches a backing store. Each core presents a read or a write request for the line. The controller serves one request at a time and records the bus transaction it caused: a read miss, an invalidate broadcast or a read-for-ownership. It then moves every core's copy to its new coherence state in the same cycle. Each core holds one line word. A single memory register stands in for the backing store.

The controller does not always fetch a missed line from memory. When a core misses on a read and another core owns the line Modified, the owner drives its word onto the bus. The memory read is dropped, the owner's word is written back into the memory register, and both the owner and the requester end up Shared. A read miss that finds other clean copies is served by the backing store and leaves all holders Shared. When there are no other copies, the requester takes the line Exclusive. It can later write to it without any bus traffic.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every core state is Invalid (encoding I=0, S=1, E=2, M=3), every core word is 0, the memory word equals MEM_INIT, `done` is 0 and `bus_op` is NONE (NONE=0, RDMISS=1, INVAL=2, RFO=3).
- R2: A read by a core in S, E or M causes no bus operation, and no state or word changes. `done` still pulses for that core.
- R3: A read miss (requester Invalid) with no other valid copy gives `bus_op`=RDMISS with `bus_mem_rd`=1. The requester receives the memory word and enters E.
- R4: A read miss while other cores hold the line only in S or E gives RDMISS with `bus_mem_rd`=1. The requester receives the memory word and enters S, and any E holder drops to S.
- R5: A read miss while another core holds the line M gives RDMISS with `bus_wb`=1 and `bus_mem_rd`=0. The requester receives the owner's word, the memory word becomes that word, and both the owner and the requester are left in S.
- R6: A write by a core in S gives `bus_op`=INVAL. Every other core goes to I, and the writer enters M holding the written word.
- R7: A write by a core in E moves it to M, and a write by a core in M keeps it in M. Both update the word with `bus_op`=NONE.
- R8: A write by a core in I gives `bus_op`=RFO. All other cores go to I and the writer enters M with the written word. A Modified owner is written back (`bus_wb`=1, `bus_mem_rd`=0); otherwise `bus_mem_rd`=1.
- R9: Exactly one request is served per cycle, the lowest-indexed active request first. One cycle after the serving edge, `done` is one-hot for that core and `bus_src` gives its index. Other requests wait.
- R10: At every cycle at most one core is in M or E, and no core is in S while any core is in M or E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | NCORE | Per-core request active; held until that core's `done` |
| req_wr | input | NCORE | Per-core request kind: 1 write, 0 read |
| req_wdata | input | NCORE*DW | Per-core write word, core j at bits j*DW +: DW |
| done | output | NCORE | One-hot pulse naming the core served at the last edge |
| line_st | output | 2*NCORE | Per-core coherence state, core j at bits 2j +: 2 |
| line_word | output | NCORE*DW | Per-core line word |
| mem_word | output | DW | Backing-store word |
| bus_op | output | 2 | Bus operation of the last served request |
| bus_src | output | IDXW | Index of the last served core |
| bus_wb | output | 1 | Last operation wrote a Modified word back |
| bus_mem_rd | output | 1 | Last operation read the backing store |

## Verification
The Exclusive state is the hardest case to reach. It appears only when a read miss finds no other copy. After the first transaction of a run, some core always holds the line, so E cannot arise again unless reset is applied. The stimulus therefore resets the block in the middle of the run at regular points. Each reset is followed by a random mix of several simultaneous reads and writes, which brings about fresh E grants, silent E-to-M upgrades and demotions of E to S. A directed opening runs the core 0/4/5 sharing, invalidate and owner-supply sequence, in which the owner supplies the word and memory is written back.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_st_t;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_RDMISS = 2'd1,
    OP_INVAL  = 2'd2,
    OP_RFO    = 2'd3
  } bus_op_t;
endpackage

// File: rtl/mesi_prio_arb.sv
module mesi_prio_arb #(
  parameter int N    = 6,
  parameter int IDXW = 3
) (
  input  logic [N-1:0]    req,
  output logic [N-1:0]    gnt,
  output logic [IDXW-1:0] gidx,
  output logic            any
);
  always_comb begin
    gnt  = '0;
    gidx = '0;
    any  = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        gnt       = '0;
        gnt[k]    = 1'b1;
        gidx      = IDXW'(k);
        any       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mesi_snoop_collect.sv
module mesi_snoop_collect #(
  parameter int N    = 6,
  parameter int IDXW = 3
) (
  input  logic [N-1:0][1:0] st,
  input  logic [IDXW-1:0]   self_idx,
  output logic              own_hit,
  output logic [IDXW-1:0]   own_idx,
  output logic [N-1:0]      peer_valid
);
  import mesi_pkg::*;

  always_comb begin
    own_hit    = 1'b0;
    own_idx    = '0;
    peer_valid = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (IDXW'(k) != self_idx) begin
        peer_valid[k] = (st[k] != ST_I);
        if (st[k] == ST_M) begin
          own_hit = 1'b1;
          own_idx = IDXW'(k);
        end
      end
    end
  end
endmodule

// File: rtl/mesi_line_slot.sv
module mesi_line_slot #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_en,
  input  logic [1:0]    st_d,
  input  logic          word_en,
  input  logic [DW-1:0] word_d,
  output logic [1:0]    st_q,
  output logic [DW-1:0] word_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= 2'd0;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl #(
  parameter int          NCORE    = 6,
  parameter int          DW       = 16,
  parameter int          IDXW     = $clog2(NCORE),
  parameter logic [DW-1:0] MEM_INIT = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCORE-1:0]      req_vld,
  input  logic [NCORE-1:0]      req_wr,
  input  logic [NCORE*DW-1:0]   req_wdata,
  output logic [NCORE-1:0]      done,
  output logic [2*NCORE-1:0]    line_st,
  output logic [NCORE*DW-1:0]   line_word,
  output logic [DW-1:0]         mem_word,
  output logic [1:0]            bus_op,
  output logic [IDXW-1:0]       bus_src,
  output logic                  bus_wb,
  output logic                  bus_mem_rd
);
  import mesi_pkg::*;

  logic [NCORE-1:0][DW-1:0] wd_a;
  logic [NCORE-1:0][1:0]    st_q, st_d;
  logic [NCORE-1:0][DW-1:0] wq_a, wrd_d;
  logic [NCORE-1:0]         st_en, wrd_en;

  logic [NCORE-1:0] gnt;
  logic [IDXW-1:0]  gidx;
  logic             g_any;
  logic             own_hit;
  logic [IDXW-1:0]  own_idx;
  logic [NCORE-1:0] peer_valid;

  logic [DW-1:0] mem_q, mem_d;
  logic          mem_en;
  bus_op_t       op_d, op_q;
  logic          wb_d, wb_q, mrd_d, mrd_q;
  logic [NCORE-1:0] done_q;
  logic [IDXW-1:0]  src_q;

  assign wd_a = req_wdata;

  mesi_prio_arb #(.N(NCORE), .IDXW(IDXW)) u_arb (
    .req  (req_vld),
    .gnt  (gnt),
    .gidx (gidx),
    .any  (g_any)
  );

  mesi_snoop_collect #(.N(NCORE), .IDXW(IDXW)) u_snoop (
    .st         (st_q),
    .self_idx   (gidx),
    .own_hit    (own_hit),
    .own_idx    (own_idx),
    .peer_valid (peer_valid)
  );

  for (genvar j = 0; j < NCORE; j++) begin : g_slot
    logic [1:0]    s_q;
    logic [DW-1:0] w_q;
    mesi_line_slot #(.DW(DW)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .st_en   (st_en[j]),
      .st_d    (st_d[j]),
      .word_en (wrd_en[j]),
      .word_d  (wrd_d[j]),
      .st_q    (s_q),
      .word_q  (w_q)
    );
    assign st_q[j] = s_q;
    assign wq_a[j] = w_q;
  end

  // Next-state: resolve the granted request against the snooped peers.
  always_comb begin
    st_d   = st_q;
    st_en  = '0;
    wrd_d  = wq_a;
    wrd_en = '0;
    mem_d  = mem_q;
    mem_en = 1'b0;
    op_d   = OP_NONE;
    wb_d   = 1'b0;
    mrd_d  = 1'b0;
    if (g_any) begin
      if (!req_wr[gidx]) begin
        if (st_q[gidx] == ST_I) begin
          op_d         = OP_RDMISS;
          st_en[gidx]  = 1'b1;
          wrd_en[gidx] = 1'b1;
          if (own_hit) begin
            // owner drives the bus; memory read dropped, owner written back
            wrd_d[gidx]   = wq_a[own_idx];
            st_d[gidx]    = ST_S;
            st_d[own_idx] = ST_S;
            st_en[own_idx] = 1'b1;
            mem_d         = wq_a[own_idx];
            mem_en        = 1'b1;
            wb_d          = 1'b1;
          end else begin
            wrd_d[gidx] = mem_q;
            mrd_d       = 1'b1;
            if (|peer_valid) begin
              st_d[gidx] = ST_S;
              for (int k = 0; k < NCORE; k++) begin
                if (peer_valid[k]) begin
                  st_d[k]  = ST_S;
                  st_en[k] = 1'b1;
                end
              end
            end else begin
              st_d[gidx] = ST_E;
            end
          end
        end
      end else begin
        st_d[gidx]   = ST_M;
        st_en[gidx]  = 1'b1;
        wrd_d[gidx]  = wd_a[gidx];
        wrd_en[gidx] = 1'b1;
        if (st_q[gidx] == ST_S || st_q[gidx] == ST_I) begin
          op_d = (st_q[gidx] == ST_S) ? OP_INVAL : OP_RFO;
          for (int k = 0; k < NCORE; k++) begin
            if (peer_valid[k]) begin
              st_d[k]  = ST_I;
              st_en[k] = 1'b1;
            end
          end
          if (st_q[gidx] == ST_I) begin
            if (own_hit) begin
              mem_d  = wq_a[own_idx];
              mem_en = 1'b1;
              wb_d   = 1'b1;
            end else begin
              mrd_d = 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= MEM_INIT;
    end else if (mem_en) begin
      mem_q <= mem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      wb_q   <= 1'b0;
      mrd_q  <= 1'b0;
      done_q <= '0;
      src_q  <= '0;
    end else begin
      op_q   <= op_d;
      wb_q   <= wb_d;
      mrd_q  <= mrd_d;
      done_q <= gnt;
      if (g_any) begin
        src_q <= gidx;
      end
    end
  end

  assign done       = done_q;
  assign line_st    = st_q;
  assign line_word  = wq_a;
  assign mem_word   = mem_q;
  assign bus_op     = op_q;
  assign bus_src    = src_q;
  assign bus_wb     = wb_q;
  assign bus_mem_rd = mrd_q;
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
  parameter int NCORE = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*NCORE-1:0] line_st,
  input logic [NCORE-1:0]   done,
  input logic [1:0]         bus_op,
  input logic               bus_wb,
  input logic               bus_mem_rd
);
  logic [NCORE-1:0] me_mask, s_mask, v_mask, m_mask;

  always_comb begin
    for (int k = 0; k < NCORE; k++) begin
      me_mask[k] = line_st[2*k+1];
      m_mask[k]  = (line_st[2*k +: 2] == 2'd3);
      s_mask[k]  = (line_st[2*k +: 2] == 2'd1);
      v_mask[k]  = (line_st[2*k +: 2] != 2'd0);
    end
  end

  a_r10_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(me_mask) <= 1);

  a_r10_no_mixed: assert property (@(posedge clk) disable iff (!rst_n)
    (|me_mask) |-> (s_mask == '0));

  a_r5_mem_abandoned: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wb |-> !bus_mem_rd);

  a_r9_one_served: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done));

  a_r2_op_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op != 2'd0) |-> (done != '0));

  a_r6_inval_sole_writer: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op == 2'd2 || bus_op == 2'd3) |->
      ($countones(v_mask) == 1 && $countones(m_mask) == 1));

  a_r3_miss_sourced: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op == 2'd1 && !bus_wb) |-> bus_mem_rd);
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.NCORE(NCORE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_st    (line_st),
  .done       (done),
  .bus_op     (bus_op),
  .bus_wb     (bus_wb),
  .bus_mem_rd (bus_mem_rd)
);

// File: tb/mesi_snoop_ctrl_tb_top.sv
module mesi_snoop_ctrl_tb_top;
  localparam int N  = 6;
  localparam int DW = 16;
  localparam int IW = 3;
  localparam logic [DW-1:0] MINIT = 16'h00A5;

  logic clk, rst_n;
  logic [N-1:0]    req_vld, req_wr;
  logic [N*DW-1:0] req_wdata;
  logic [N-1:0]    done;
  logic [2*N-1:0]  line_st;
  logic [N*DW-1:0] line_word;
  logic [DW-1:0]   mem_word;
  logic [1:0]      bus_op;
  logic [IW-1:0]   bus_src;
  logic            bus_wb, bus_mem_rd;

  mesi_snoop_ctrl #(.NCORE(N), .DW(DW), .IDXW(IW), .MEM_INIT(MINIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .req_wdata(req_wdata), .done(done), .line_st(line_st),
    .line_word(line_word), .mem_word(mem_word), .bus_op(bus_op),
    .bus_src(bus_src), .bus_wb(bus_wb), .bus_mem_rd(bus_mem_rd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [1:0]    m_st [N];
  logic [DW-1:0] m_dat [N];
  logic [DW-1:0] m_mem;
  logic [1:0]    e_op;
  logic          e_wb, e_mrd;
  string         e_tag;
  logic          b_wr [N];
  logic [DW-1:0] b_wd [N];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int lowest(logic [N-1:0] m);
    for (int k = N - 1; k >= 0; k--) if (m[k]) lowest = k;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++; nchk++;
      $display("FAIL R9 watchdog act=%0d exp=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic model_serve(int g, bit wr, logic [DW-1:0] wd);
    int own = -1;
    bit anyv = 0;
    e_op = 0; e_wb = 0; e_mrd = 0;
    for (int j = N - 1; j >= 0; j--) if (j != g) begin
      if (m_st[j] == 2'd3) own = j;
      if (m_st[j] != 2'd0) anyv = 1;
    end
    if (!wr) begin
      if (m_st[g] != 2'd0) e_tag = "R2";
      else begin
        e_op = 1;
        if (own >= 0) begin
          e_tag = "R5"; m_dat[g] = m_dat[own]; m_mem = m_dat[own];
          m_st[own] = 2'd1; m_st[g] = 2'd1; e_wb = 1;
        end else if (anyv) begin
          e_tag = "R4"; m_dat[g] = m_mem; e_mrd = 1;
          for (int j = 0; j < N; j++) if (m_st[j] != 2'd0) m_st[j] = 2'd1;
          m_st[g] = 2'd1;
        end else begin
          e_tag = "R3"; m_dat[g] = m_mem; m_st[g] = 2'd2; e_mrd = 1;
        end
      end
    end else begin
      if (m_st[g] >= 2'd2) e_tag = "R7";
      else begin
        if (m_st[g] == 2'd1) begin e_tag = "R6"; e_op = 2; end
        else begin
          e_tag = "R8"; e_op = 3;
          if (own >= 0) begin m_mem = m_dat[own]; e_wb = 1; end
          else e_mrd = 1;
        end
        for (int j = 0; j < N; j++) if (j != g) m_st[j] = 2'd0;
      end
      m_st[g] = 2'd3; m_dat[g] = wd;
    end
  endtask

  task automatic check_lines(string tag);
    int nme = 0, ns = 0;
    for (int j = 0; j < N; j++) begin
      chk(line_st[2*j +: 2] == m_st[j], tag, $sformatf("state core%0d", j),
          int'(line_st[2*j +: 2]), int'(m_st[j]));
      if (m_st[j] != 2'd0)
        chk(line_word[j*DW +: DW] == m_dat[j], tag, $sformatf("word core%0d", j),
            int'(line_word[j*DW +: DW]), int'(m_dat[j]));
      if (line_st[2*j+1]) nme++;
      if (line_st[2*j +: 2] == 2'd1) ns++;
    end
    chk(mem_word == m_mem, tag, "mem", int'(mem_word), int'(m_mem));
    chk(nme <= 1 && !(nme == 1 && ns > 0), "R10", "owner invariant", nme, ns);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_vld = '0;
    for (int j = 0; j < N; j++) begin m_st[j] = 0; m_dat[j] = 0; end
    m_mem = MINIT;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int j = 0; j < N; j++)
      chk(line_word[j*DW +: DW] == '0, "R1", "reset word", int'(line_word[j*DW +: DW]), 0);
    chk(done == '0 && bus_op == 2'd0, "R1", "reset bus", int'(bus_op), 0);
    check_lines("R1");
  endtask

  // serve all cores in mask; b_wr/b_wd hold the kinds and words
  task automatic run_batch(logic [N-1:0] mask);
    logic [N-1:0] pend = mask;
    while (pend != '0) begin
      int g;
      req_vld = pend;
      for (int j = 0; j < N; j++) begin
        req_wr[j] = b_wr[j];
        req_wdata[j*DW +: DW] = b_wd[j];
      end
      @(posedge clk);
      @(negedge clk);
      g = lowest(pend);
      model_serve(g, b_wr[g], b_wd[g]);
      chk(done == (N'(1) << g), "R9", "done", int'(done), 1 << g);
      chk(bus_src == IW'(g), "R9", "bus_src", int'(bus_src), g);
      chk(bus_op == e_op, e_tag, "bus_op", int'(bus_op), int'(e_op));
      chk(bus_wb == e_wb, e_tag, "bus_wb", int'(bus_wb), int'(e_wb));
      chk(bus_mem_rd == e_mrd, e_tag, "bus_mem_rd", int'(bus_mem_rd), int'(e_mrd));
      check_lines(e_tag);
      pend[g] = 1'b0;
    end
    req_vld = '0;
  endtask

  task automatic one(int c, bit wr, logic [DW-1:0] wd);
    b_wr[c] = wr; b_wd[c] = wd;
    run_batch(N'(1) << c);
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; req_vld = '0; req_wr = '0; req_wdata = '0;
    for (int j = 0; j < N; j++) begin b_wr[j] = 0; b_wd[j] = 0; end
    do_reset();
    // directed: sharing, invalidate, owner supply, clean refill
    one(0, 0, 0);          // R3 exclusive
    one(4, 0, 0);          // R4 E demoted
    one(5, 0, 0);          // R4
    one(0, 1, 16'h00C8);   // R6 invalidate
    one(4, 0, 0);          // R5 owner supplies
    one(5, 0, 0);          // R4 from memory
    one(5, 0, 0);          // R2 hit
    one(5, 1, 16'h1111);   // R6
    one(5, 1, 16'h2222);   // R7 M hit
    one(2, 1, 16'h3333);   // R8 with writeback
    one(1, 0, 0);          // R5
    one(3, 1, 16'h4444);   // R8 no owner
    do_reset();
    one(2, 0, 0);          // R3
    one(2, 1, 16'h5555);   // R7 silent E->M
    // same-cycle requests: priority
    b_wr[1] = 0; b_wr[3] = 1; b_wd[3] = 16'h6666; b_wr[4] = 0;
    run_batch(6'b011010);
    @(negedge clk);
    chk(done == '0 && bus_op == 2'd0, "R9", "idle", int'(done), 0);
    for (int it = 0; it < 600; it++) begin
      logic [N-1:0] mask;
      if (it % 40 == 39) do_reset();
      mask = N'($urandom_range(1, (1 << N) - 1));
      if ($urandom_range(0, 1) == 1) mask = N'(1) << $urandom_range(0, N - 1);
      for (int j = 0; j < N; j++) begin
        b_wr[j] = ($urandom_range(0, 2) == 0);
        b_wd[j] = DW'($urandom);
      end
      run_batch(mask);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule